// File: doc/BRIEF.md
# StreamID Span Filter

This block decides, one transaction at a time, whether a StreamID seen by a monitor counter should be counted. Software programs a match value, a span flag and a filter enable. With the span flag clear the StreamID must equal the match value bit for bit. With the span flag set, the match value carries its own wildcard width: a run of trailing ones closed by a zero bit marks the low bits that are ignored. The bits above that zero are compared. With the filter enable low, every StreamID counts.

StreamIDs arrive on a valid/ready input and leave as a one-bit hit decision on a valid/ready output, one register stage later. Back-pressure rule: `s_ready` is high whenever the output register is empty or is being drained in the same cycle (`!m_valid || m_ready`). While `m_valid` is high and `m_ready` is low, the held decision does not change and no new StreamID is taken. The configuration inputs are plain levels. They are sampled in the cycle a StreamID is accepted.

Top module: `sid_span_filter`

## Requirements
- R1: With filter enabled and span clear, the decision is a hit only when every StreamID bit equals the match value.
- R2: With filter enabled and span set, the ignored bits are the lowest zero bit of the match value and every bit below it; all bits above must equal the StreamID.
- R3: Match value 0x42 with span set gives a hit for StreamIDs 0x42 and 0x43 and a miss for 0x40, 0x41, 0x44 and 0xC2.
- R4: Match value of all ones with span set gives a hit for every StreamID.
- R5: With the filter enable low, every accepted StreamID gives a hit, whatever the span flag and match value.
- R6: A StreamID accepted at a clock edge (`s_valid && s_ready`) produces `m_valid` high after that edge; `m_hit` is never high while `m_valid` is low.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_hit` holds its value.
- R8: `s_ready` equals `!m_valid || m_ready`, so a held decision can be drained and a new StreamID accepted at the same edge.
- R9: The decision uses the configuration present at the accepting edge; later configuration changes do not alter a held decision.
- R10: After reset `m_valid` and `m_hit` are low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_filter_en | input | 1 | 1 = apply the filter, 0 = every StreamID hits |
| cfg_span | input | 1 | 0 = exact compare, 1 = trailing-ones wildcard compare |
| cfg_match | input | SID_W (32) | Programmed match value |
| s_valid | input | 1 | StreamID present |
| s_ready | output | 1 | Filter can take a StreamID |
| s_sid | input | SID_W (32) | StreamID of the transaction |
| m_valid | output | 1 | Decision present |
| m_ready | input | 1 | Consumer takes the decision |
| m_hit | output | 1 | 1 = transaction is counted |

## Verification
The output register can hand a held decision to the consumer in the same cycle that it loads the next StreamID, and a configuration change can land in the same cycle a StreamID is accepted. Both are provoked by back-to-back valid StreamIDs with `m_ready` high, by random `m_ready` stalls, and by reprogramming the match value and span flag at the accepting edge and again while a decision is held. Each cycle the bench compares `m_valid`, `m_hit` and `s_ready` with a reference model that latches a decision computed from the requirements at every accepting edge, so a decision taken from the wrong cycle's configuration or lost in a simultaneous drain shows as a mismatch.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // How the wildcard mask is derived from the match value.
  typedef enum logic [0:0] {
    MASK_CARRY = 1'b0,   // value XOR (value + 1)
    MASK_CHAIN = 1'b1    // AND chain over trailing ones
  } spf_mask_style_e;

  // Configuration as it is applied to one compare.
  typedef struct packed {
    logic en;
    logic span;
  } spf_mode_t;
endpackage

// File: rtl/spf_mask_gen.sv
module spf_mask_gen
  import spf_pkg::*;
#(
  parameter int              SID_W      = 32,
  parameter spf_mask_style_e MASK_STYLE = MASK_CARRY
) (
  input  logic [SID_W-1:0] match_val,
  output logic [SID_W-1:0] ignore_mask
);

  generate
    if (MASK_STYLE == MASK_CARRY) begin : g_carry
      logic [SID_W-1:0] bumped;
      // Adding one flips the trailing ones and the first zero; XOR keeps
      // exactly those flipped bits. All ones wraps to zero: full mask.
      assign bumped      = match_val + {{(SID_W-1){1'b0}}, 1'b1};
      assign ignore_mask = match_val ^ bumped;
    end else begin : g_chain
      logic [SID_W-1:0] run;
      assign run[0] = 1'b1;
      for (genvar i = 1; i < SID_W; i++) begin : g_bit
        assign run[i] = run[i-1] & match_val[i-1];
      end
      assign ignore_mask = run;
    end
  endgenerate

endmodule

// File: rtl/spf_match.sv
module spf_match
  import spf_pkg::*;
#(
  parameter int SID_W = 32
) (
  input  spf_mode_t        mode,
  input  logic [SID_W-1:0] match_val,
  input  logic [SID_W-1:0] ignore_mask,
  input  logic [SID_W-1:0] sid,
  output logic             hit
);

  logic [SID_W-1:0] diff;
  logic [SID_W-1:0] care;
  logic             exact_ok;
  logic             span_ok;

  assign diff     = sid ^ match_val;
  assign care     = ~ignore_mask;
  assign exact_ok = ~|diff;
  assign span_ok  = ~|(diff & care);

  always_comb begin
    if (!mode.en)        hit = 1'b1;
    else if (mode.span)  hit = span_ok;
    else                 hit = exact_ok;
  end

endmodule

// File: rtl/spf_out_reg.sv
module spf_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_hit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_hit
);

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_hit   <= in_valid & in_hit;
    end
  end

  // R6
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);

  // R6
  accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  stall_holds_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R7
  stall_holds_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_hit));

endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
  import spf_pkg::*;
#(
  parameter int              SID_W      = 32,
  parameter spf_mask_style_e MASK_STYLE = MASK_CARRY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_filter_en,
  input  logic             cfg_span,
  input  logic [SID_W-1:0] cfg_match,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SID_W-1:0] s_sid,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_hit
);

  spf_mode_t        mode;
  logic [SID_W-1:0] ignore_mask;
  logic             cmp_hit;

  assign mode.en   = cfg_filter_en;
  assign mode.span = cfg_span;

  spf_mask_gen #(
    .SID_W      (SID_W),
    .MASK_STYLE (MASK_STYLE)
  ) u_mask (
    .match_val   (cfg_match),
    .ignore_mask (ignore_mask)
  );

  spf_match #(
    .SID_W (SID_W)
  ) u_match (
    .mode        (mode),
    .match_val   (cfg_match),
    .ignore_mask (ignore_mask),
    .sid         (s_sid),
    .hit         (cmp_hit)
  );

  spf_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_hit    (cmp_hit),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_hit   (m_hit)
  );

  // R4
  all_ones_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_filter_en && cfg_span && (&cfg_match) && s_valid) |-> cmp_hit);

  // R5
  bypass_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_filter_en && s_valid) |-> cmp_hit);

  // R2
  mask_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> ignore_mask[0]);

endmodule

// File: tb/tb_sid_span_filter.sv
`timescale 1ns/1ps
module tb_sid_span_filter;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b1;
  logic         span = 1'b0;
  logic [W-1:0] mval = '0;
  logic         sv = 1'b0;
  logic [W-1:0] sid = '0;
  logic         mr = 1'b1;
  logic         s_ready, m_valid, m_hit;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  sid_span_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_filter_en(en), .cfg_span(span),
    .cfg_match(mval), .s_valid(sv), .s_ready(s_ready), .s_sid(sid),
    .m_valid(m_valid), .m_ready(mr), .m_hit(m_hit)
  );

  function automatic bit ref_hit(bit f_en, bit f_span, logic [W-1:0] v,
                                 logic [W-1:0] s);
    logic [W-1:0] keep;
    bit           seen_zero;
    if (!f_en) return 1'b1;
    if (!f_span) return (v == s);
    keep = '1;
    seen_zero = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!seen_zero) keep[i] = 1'b0;
      if (v[i] == 1'b0) seen_zero = 1'b1;
    end
    return ((v & keep) == (s & keep));
  endfunction

  // Reference output register.
  logic ev, eh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev <= 1'b0;
      eh <= 1'b0;
    end else if (!ev || mr) begin
      ev <= sv;
      eh <= sv && ref_hit(en, span, mval, sid);
    end
  end

  task automatic check_bit(string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    check_bit("m_valid", m_valid, ev);
    check_bit("m_hit", m_hit, ev ? eh : 1'b0);
    check_bit("s_ready", s_ready, !ev || mr);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic send(logic [W-1:0] id);
    sv = 1'b1;
    sid = id;
    tick();
  endtask

  task automatic idle();
    sv = 1'b0;
    tick();
  endtask

  // Random span-encoded value: low y bits ignored.
  function automatic logic [W-1:0] span_val(int y, logic [W-1:0] upper);
    logic [W-1:0] v;
    if (y >= W) return '1;
    v = upper;
    for (int i = 0; i < y; i++) v[i] = (i == y - 1) ? 1'b0 : 1'b1;
    return v;
  endfunction

  initial begin : wd
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    cur_req = "R10";
    check_all();
    check_bit("reset m_valid", m_valid, 1'b0);
    check_bit("reset s_ready", s_ready, 1'b1);
    rst_n = 1'b1;
    tick();

    // R1 exact compare
    cur_req = "R1";
    en = 1; span = 0; mval = 32'h0000_1234; mr = 1;
    send(32'h0000_1234);
    send(32'h0000_1235);
    send(32'h8000_1234);
    send(32'h0000_1234);
    idle();

    // R3 pattern 0x42
    cur_req = "R3";
    span = 1; mval = 32'h42;
    send(32'h42); send(32'h43); send(32'h40); send(32'h41);
    send(32'h44); send(32'hC2);
    idle();

    // R4 all ones
    cur_req = "R4";
    mval = '1;
    send(32'h0); send(32'hDEAD_BEEF); send('1);
    for (int i = 0; i < 20; i++) send($urandom);
    idle();

    // R5 bypass
    cur_req = "R5";
    en = 0; span = 0; mval = 32'h7;
    send(32'h0); send(32'h1234_5678);
    span = 1;
    send(32'hFFFF_0000);
    idle();
    en = 1;

    // R2 random span widths, near-miss StreamIDs
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int y;
      y = 1 + int'($urandom % W);
      span = 1;
      mval = span_val(y, $urandom);
      case ($urandom % 3)
        0: send(mval ^ (($urandom) & ((32'h1 << (y - 1)) - 1)));
        1: send(mval ^ (32'h1 << ($urandom % W)));
        default: send($urandom);
      endcase
    end
    idle();

    // R7 stall: output held, input refused
    cur_req = "R7";
    span = 0; mval = 32'hAB;
    send(32'hAB);
    mr = 0;
    send(32'h11);
    send(32'h22);
    send(32'hAB);
    mr = 1;
    tick();
    idle();

    // R9 config change at and after the accepting edge
    cur_req = "R9";
    mval = 32'h55; span = 0;
    mr = 0;
    send(32'h55);
    mval = 32'h66; span = 1; en = 0;
    tick(); tick();
    en = 1;
    mr = 1;
    idle();

    // R8 drain and accept at the same edge, config flips each cycle
    cur_req = "R8";
    for (int i = 0; i < 40; i++) begin
      span = i[0];
      mval = (i % 4 == 0) ? 32'h42 : span_val(1 + (i % 8), 32'h300);
      mr = (i % 5 != 0);
      send(32'h300 + i);
    end
    mr = 1;
    idle();

    // R6 mixed random traffic with random back-pressure
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      en   = ($urandom % 8) != 0;
      span = $urandom;
      mval = span ? span_val(1 + int'($urandom % W), $urandom) : ($urandom % 16);
      sid  = ($urandom % 2) ? (mval ^ ($urandom % 4)) : ($urandom % 16);
      sv   = $urandom;
      mr   = ($urandom % 4) != 0;
      tick();
    end
    mr = 1;
    idle();
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule